// File: doc/BRIEF.md
# Four-Channel PWM with Shadowed Settings

The block generates four independent pulse-width-modulated outputs from one clock. Each channel has a prescaler that stretches every counting step over several clock cycles, a modulus that sets how many steps form one period, a duty value that sets how many steps at the start of the period the output stays high, and an enable bit. Software programs these values through a simple single-cycle register port. Writes are captured on the rising clock edge. Reads are combinational from the address.

Prescale and modulus writes go into shadow registers only. A write to a channel's duty register commits the three shadow values as one set. While the channel runs, the committed set is loaded at the end of the current period, so every period uses a single consistent setting. The modulus and prescale must therefore be written before the duty. Clearing the enable bit does not wait for the period to end. The output drops at once and the counters restart, so the next enable begins a clean period with the latest committed set.

Top module: `pwm_quad`

## Requirements
- R1: Byte address bits [6:5] select the channel. Bits [4:0] select the register: 0x00 prescale (8 bits), 0x04 modulus (8 bits), 0x08 duty (16 bits), 0x18 enable (bit 0). Reads return the last written value, and bits above each field read as zero.
- R2: Offsets other than the four above read as zero. Writes to them change no register.
- R3: While enabled, one output period lasts (prescale+1) × modulus clock cycles. A modulus of 0 counts as one step.
- R4: In each period the output is high for the first (prescale+1) × duty cycles and low for the rest.
- R5: A duty of 0 holds the output low. A duty greater than or equal to the modulus holds it high.
- R6: Writes to prescale or modulus do not change the output until the channel's duty register is written.
- R7: A commit made while the channel runs takes effect at the next period boundary. The period in progress completes with the old settings.
- R8: The output is low in the cycle after the edge that clears enable. Setting enable again starts a new period at its beginning, high first, with the committed settings.
- R9: Each channel's settings and output are independent of the other channels.
- R10: After reset all registers read zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the counters and the register port |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, captured on the rising edge |
| addr_i | input | 7 | Byte address: channel in [6:5], register offset in [4:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 4 | PWM outputs, bit n for channel n |

## Verification
The bench builds the block with its default parameters: four channels, an 8-bit prescaler, an 8-bit modulus and a 16-bit duty field. With an 8-bit modulus the duty can exceed it, so the always-high case can be reached. Prescale values up to 3 and moduli up to about 100 keep every period short. This lets the bench measure many randomly configured periods and the boundary-commit and immediate-stop cases in one short run.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
  localparam int CH_SHIFT = 5;
  localparam logic [CH_SHIFT-1:0] OFF_PRE  = 5'h00;
  localparam logic [CH_SHIFT-1:0] OFF_MOD  = 5'h04;
  localparam logic [CH_SHIFT-1:0] OFF_DUTY = 5'h08;
  localparam logic [CH_SHIFT-1:0] OFF_EN   = 5'h18;
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DW     = 32,
  parameter int AW     = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [DW-1:0]                rdata_o,
  output logic [N_CH-1:0][PRE_W-1:0]   pre_o,
  output logic [N_CH-1:0][MOD_W-1:0]   mod_o,
  output logic [N_CH-1:0][DUTY_W-1:0]  duty_o,
  output logic [N_CH-1:0]              en_o,
  output logic [N_CH-1:0]              commit_o
);
  localparam int CW = AW - CH_SHIFT;

  logic [CW-1:0]       ch_sel;
  logic [CH_SHIFT-1:0] off;
  logic                ch_ok;
  logic                off_mapped;

  assign ch_sel     = addr_i[AW-1:CH_SHIFT];
  assign off        = addr_i[CH_SHIFT-1:0];
  assign ch_ok      = (int'(ch_sel) < N_CH);
  assign off_mapped = (off == OFF_PRE) || (off == OFF_MOD) ||
                      (off == OFF_DUTY) || (off == OFF_EN);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic              hit;
    logic [PRE_W-1:0]  pre_q;
    logic [MOD_W-1:0]  mod_q;
    logic [DUTY_W-1:0] duty_q;
    logic              en_q;

    assign hit = wr_en_i && ch_ok && (int'(ch_sel) == g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pre_q  <= '0;
        mod_q  <= '0;
        duty_q <= '0;
        en_q   <= 1'b0;
      end else if (hit) begin
        case (off)
          OFF_PRE:  pre_q  <= wdata_i[PRE_W-1:0];
          OFF_MOD:  mod_q  <= wdata_i[MOD_W-1:0];
          OFF_DUTY: duty_q <= wdata_i[DUTY_W-1:0];
          OFF_EN:   en_q   <= wdata_i[0];
          default: ;
        endcase
      end
    end

    assign pre_o[g]    = pre_q;
    assign mod_o[g]    = mod_q;
    assign duty_o[g]   = duty_q;
    assign en_o[g]     = en_q;
    // duty write arms the commit of the whole shadow set
    assign commit_o[g] = hit && (off == OFF_DUTY);
  end

  always_comb begin
    rdata_o = '0;
    if (ch_ok) begin
      case (off)
        OFF_PRE:  rdata_o[PRE_W-1:0]  = pre_o[ch_sel];
        OFF_MOD:  rdata_o[MOD_W-1:0]  = mod_o[ch_sel];
        OFF_DUTY: rdata_o[DUTY_W-1:0] = duty_o[ch_sel];
        OFF_EN:   rdata_o[0]          = en_o[ch_sel];
        default: ;
      endcase
    end
  end

  p_unmapped_write_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !off_mapped) |=> ($stable(pre_o) && $stable(mod_o) &&
                                  $stable(duty_o) && $stable(en_o)));

  p_commit_single_channel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(commit_o));
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              commit_i,
  input  logic [PRE_W-1:0]  pre_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic              pend_q;
  logic [PRE_W-1:0]  act_pre_q;
  logic [MOD_W-1:0]  act_mod_q;
  logic [DUTY_W-1:0] act_duty_q;
  logic [PRE_W-1:0]  pcnt_q;
  logic [MOD_W-1:0]  scnt_q;
  logic [MOD_W-1:0]  last_step;
  logic              step_end;
  logic              per_end;
  logic              apply;

  assign last_step = (act_mod_q == '0) ? '0 : act_mod_q - MOD_W'(1);
  assign step_end  = (pcnt_q == act_pre_q);
  assign per_end   = step_end && (scnt_q == last_step);
  // idle channel takes a commit at once, running channel at the boundary
  assign apply     = pend_q && (!en_i || per_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      act_pre_q  <= '0;
      act_mod_q  <= '0;
      act_duty_q <= '0;
    end else begin
      pend_q <= commit_i || (pend_q && !apply);
      if (apply) begin
        act_pre_q  <= pre_i;
        act_mod_q  <= mod_i;
        act_duty_q <= duty_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      scnt_q <= '0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      scnt_q <= '0;
    end else if (step_end) begin
      pcnt_q <= '0;
      scnt_q <= per_end ? '0 : scnt_q + MOD_W'(1);
    end else begin
      pcnt_q <= pcnt_q + PRE_W'(1);
    end
  end

  assign pwm_o = en_i && (DUTY_W'(scnt_q) < act_duty_q);

  p_cfg_frozen_mid_period_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_end) |=> ($stable(act_pre_q) && $stable(act_mod_q) && $stable(act_duty_q)));

  p_step_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (scnt_q <= last_step));

  p_stop_resets_counters_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |=> (pcnt_q == '0 && scnt_q == '0));
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int N_CH   = 4,
  parameter int PRE_W  = 8,
  parameter int MOD_W  = 8,
  parameter int DUTY_W = 16,
  parameter int DW     = 32,
  localparam int AW    = pwm_quad_pkg::CH_SHIFT + $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [N_CH-1:0] pwm_o
);
  logic [N_CH-1:0][PRE_W-1:0]  pre_s;
  logic [N_CH-1:0][MOD_W-1:0]  mod_s;
  logic [N_CH-1:0][DUTY_W-1:0] duty_s;
  logic [N_CH-1:0]             en_s;
  logic [N_CH-1:0]             commit_s;

  pwm_quad_regs #(
    .N_CH(N_CH), .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W), .DW(DW), .AW(AW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pre_o    (pre_s),
    .mod_o    (mod_s),
    .duty_o   (duty_s),
    .en_o     (en_s),
    .commit_o (commit_s)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_chan
    pwm_quad_chan #(
      .PRE_W(PRE_W), .MOD_W(MOD_W), .DUTY_W(DUTY_W)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_s[g]),
      .commit_i (commit_s[g]),
      .pre_i    (pre_s[g]),
      .mod_i    (mod_s[g]),
      .duty_i   (duty_s[g]),
      .pwm_o    (pwm_o[g])
    );
  end
endmodule

// File: tb/sim_pwm_quad.sv
module sim_pwm_quad;
  localparam int R_PRE = 'h00, R_MOD = 'h04, R_DUTY = 'h08, R_EN = 'h18;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  int          n_tests = 0;
  int          n_fails = 0;

  always #4 clk = ~clk;

  pwm_quad u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic int exp_hi(int p, int m, int d);
    int steps = (m == 0) ? 1 : m;
    return (p + 1) * ((d > steps) ? steps : d);
  endfunction

  function automatic int exp_per(int p, int m);
    return (p + 1) * ((m == 0) ? 1 : m);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input int data);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = 7'((ch << 5) | off);
    wdata = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output int data);
    @(negedge clk);
    wr_en = 1'b0;
    addr  = 7'((ch << 5) | off);
    #1 data = rdata;
  endtask

  task automatic cfg(input int ch, input int p, input int m, input int d);
    wr(ch, R_EN, 0);
    wr(ch, R_PRE, p);
    wr(ch, R_MOD, m);
    wr(ch, R_DUTY, d);
    wr(ch, R_EN, 1);
  endtask

  // waits for a full period start, then times high and low phases
  task automatic measure(input int ch, output int hi, output int per);
    int lo;
    @(negedge clk);
    while (pwm[ch]) @(negedge clk);
    while (!pwm[ch]) @(negedge clk);
    hi = 0;
    while (pwm[ch]) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pwm[ch]) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic count_high(input int ch, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch]) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fails++;
    $display("FAIL R3 watchdog: actual=150000 cycles expected=fewer");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

  initial begin
    int v, hi, per, p, m, d, ch, cnt;
    void'($urandom(32'd2718));
    rst_n = 1'b0;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 outputs low in reset", int'(pwm), 0);
    rst_n = 1'b1;

    // R10 reset values
    for (int c = 0; c < 4; c++) begin
      rd(c, R_PRE, v);  chk("R10 prescale reset", v, 0);
      rd(c, R_MOD, v);  chk("R10 modulus reset", v, 0);
      rd(c, R_DUTY, v); chk("R10 duty reset", v, 0);
      rd(c, R_EN, v);   chk("R10 enable reset", v, 0);
    end
    chk("R10 outputs low after reset", int'(pwm), 0);

    // R1 field widths, unused bits read zero
    wr(2, R_PRE, 32'hFFFF_FFFF);
    wr(2, R_MOD, 32'hFFFF_FFFF);
    wr(2, R_DUTY, 32'hFFFF_FFFF);
    rd(2, R_PRE, v);  chk("R1 prescale width", v, 'hFF);
    rd(2, R_MOD, v);  chk("R1 modulus width", v, 'hFF);
    rd(2, R_DUTY, v); chk("R1 duty width", v, 'hFFFF);
    wr(2, R_EN, 32'hFFFF_FFFF);
    rd(2, R_EN, v);   chk("R1 enable bit0", v, 1);
    wr(2, R_EN, 0);
    rd(1, R_MOD, v);  chk("R1 R9 other channel untouched", v, 0);

    // R2 unmapped offsets
    wr(0, R_PRE, 3); wr(0, R_MOD, 9); wr(0, R_DUTY, 4);
    wr(0, 'h0C, -1); wr(0, 'h10, -1); wr(0, 'h14, -1); wr(0, 'h1C, -1); wr(0, 'h06, -1);
    rd(0, 'h0C, v); chk("R2 unmapped 0x0C reads zero", v, 0);
    rd(0, 'h1C, v); chk("R2 unmapped 0x1C reads zero", v, 0);
    rd(0, R_PRE, v); chk("R2 prescale unchanged", v, 3);
    rd(0, R_MOD, v); chk("R2 modulus unchanged", v, 9);
    rd(0, R_DUTY, v); chk("R2 duty unchanged", v, 4);
    rd(0, R_EN, v); chk("R2 enable unchanged", v, 0);
    chk("R2 output unchanged", int'(pwm[0]), 0);

    // R3 R4 random configurations
    for (int k = 0; k < 14; k++) begin
      ch = int'($urandom % 4);
      p  = int'($urandom % 4);
      m  = 2 + int'($urandom % 30);
      d  = 1 + int'($urandom % (m - 1));
      cfg(ch, p, m, d);
      measure(ch, hi, per);
      chk($sformatf("R4 high time ch%0d p%0d m%0d d%0d", ch, p, m, d), hi, exp_hi(p, m, d));
      chk($sformatf("R3 period ch%0d p%0d m%0d d%0d", ch, p, m, d), per, exp_per(p, m));
      rd(ch, R_DUTY, v);
      chk("R1 duty readback", v, d);
    end
    for (int c = 0; c < 4; c++) wr(c, R_EN, 0);

    // R9 concurrent channels
    cfg(0, 0, 10, 3);
    cfg(3, 1, 6, 5);
    measure(0, hi, per);
    chk("R9 ch0 high", hi, 3);
    chk("R9 ch0 period", per, 10);
    measure(3, hi, per);
    chk("R9 ch3 high", hi, 10);
    chk("R9 ch3 period", per, 12);
    wr(0, R_EN, 0);
    wr(3, R_EN, 0);

    // R5 extremes
    cfg(3, 0, 8, 0);
    count_high(3, 30, cnt);
    chk("R5 duty zero stays low", cnt, 0);
    wr(3, R_DUTY, 8);
    repeat (12) @(negedge clk);
    count_high(3, 30, cnt);
    chk("R5 duty equal modulus stays high", cnt, 30);
    wr(3, R_DUTY, 200);
    repeat (12) @(negedge clk);
    count_high(3, 30, cnt);
    chk("R5 duty above modulus stays high", cnt, 30);
    wr(3, R_EN, 0);

    // R6 prescale and modulus wait for duty write
    cfg(2, 2, 10, 4);
    measure(2, hi, per);
    chk("R6 baseline high", hi, 12);
    chk("R6 baseline period", per, 30);
    wr(2, R_MOD, 20);
    wr(2, R_PRE, 0);
    measure(2, hi, per);
    chk("R6 uncommitted high", hi, 12);
    chk("R6 uncommitted period", per, 30);
    wr(2, R_DUTY, 4);
    measure(2, hi, per);
    chk("R6 committed high", hi, 4);
    chk("R6 committed period", per, 20);
    wr(2, R_EN, 0);

    // R7 commit mid-period waits for boundary
    cfg(1, 0, 100, 80);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm[1]) hi++;
      @(negedge clk);
    end
    if (pwm[1]) hi++;
    wr_en = 1'b1;
    addr  = 7'((1 << 5) | R_DUTY);
    wdata = 5;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm[1]) begin hi++; @(negedge clk); end
    chk("R7 running period keeps old duty", hi, 80);
    measure(1, hi, per);
    chk("R7 new duty after boundary", hi, 5);
    chk("R7 period after boundary", per, 100);

    // R8 immediate stop and fresh restart
    cfg(1, 1, 20, 10);
    measure(1, hi, per);
    chk("R8 running high", hi, 20);
    @(negedge clk);
    while (!pwm[1]) @(negedge clk);
    repeat (3) @(negedge clk);
    wr(1, R_EN, 0);
    chk("R8 low right after disable", int'(pwm[1]), 0);
    count_high(1, 25, cnt);
    chk("R8 stays low while disabled", cnt, 0);
    wr(1, R_EN, 1);
    hi = 0;
    while (pwm[1]) begin hi++; @(negedge clk); end
    chk("R8 restart full high phase", hi, 20);
    wr(1, R_EN, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end
endmodule